// File: doc/BRIEF.md
# DDR Write-Then-Verify Pattern Tester

This block sits on the user side of a DDR memory controller and runs a self-contained memory test. It waits after reset until a pushbutton edge arrives. It then streams a counting pattern into a fixed set of rows, row by row, covering every column. After that it reads the same region back and compares each returned word with a regenerated copy of the pattern. Mismatches are counted, and the result is shown as a pass or fail LED pattern.

Each 32-bit user word carries two consecutive 16-bit counts, with the earlier count in the upper half. A row is offered to the controller as one continuous stream. The block advances only on the cycles in which the controller accepts write data or presents valid read data. Any stall the controller inserts, such as an auto-refresh pause, therefore leaves the test at the same row, column and pattern value. A one-cycle row marker closes each row. The error counter saturates, and a separate sticky flag makes sure that any error always shows as a failure.

Top module: `ddr_pattern_tester`

## Requirements
- R1: After reset, `cmd_req`, `row_done`, `err_count` and `leds` are all zero, and the block stays idle until `start_btn` rises. A rising edge of `start_btn` while a test is running has no effect on the address or data sequence.
- R2: Write word k of the test, counted from 0 across all rows, equals {16'(2k), 16'(2k+1)}, with the upper 16 bits holding the first count. Counts wrap modulo 2^16.
- R3: `cmd_rd` is 0 during the write phase and 1 during the read phase. In each phase, rows run from 0 to ROWS-1 in order. Within a row, `col_addr` starts at 0 and advances by 2 for each word transferred, giving COLS/2 words per row.
- R4: `row_done` is high for exactly one cycle, directly after the last word of a row has been transferred, and never in the middle of a row. `cmd_req` is low in that cycle.
- R5: A cycle in the write phase without `wr_take`, or in the read phase without `rd_valid`, keeps the row, the column and the offered write word. After such a pause the stream continues without skipping or repeating a word.
- R6: The expected read value starts again at the first pattern word {0x0000, 0x0001} when the read phase begins. It advances by one word only on cycles where `rd_valid` is high.
- R7: Each valid read word that differs from the expected word raises `err_count` by one. The count saturates at 2^ERR_W-1 and does not wrap.
- R8: After the read phase ends, `leds` shows 0x01 if no mismatch occurred and 0x3F (the low six LEDs) otherwise. At all other times `leds` is 0.
- R9: `rd_valid` is ignored during the write phase, and `wr_take` is ignored during the read phase.
- R10: A new start from the finished state clears `err_count`, the fail flag and `leds`, and reruns the whole test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_btn | input | 1 | Pushbutton level; a rising edge starts a test |
| wr_take | input | 1 | Controller accepts the offered write word this cycle |
| rd_valid | input | 1 | Controller presents a valid read word this cycle |
| rd_word | input | 2*HALF_W | Read data from the controller |
| cmd_req | output | 1 | A row stream is being requested |
| cmd_rd | output | 1 | 1 = read stream, 0 = write stream |
| row_addr | output | ROW_W | Current row |
| col_addr | output | COL_W | Current column (even) |
| wr_word | output | 2*HALF_W | Write data offered to the controller |
| row_done | output | 1 | One-cycle marker at the end of each row |
| err_count | output | ERR_W | Saturating mismatch count |
| leds | output | LED_W | Result pattern |

## Verification
A column or pattern counter that slips during a stall shows up at once as a wrong `col_addr` or `wr_word` on the next accepted write. A read-side slip shows up as a jump in `err_count` one cycle after the affected read word. A row counter that steps at the wrong point shows up as a wrong `row_addr`, or as `row_done` missing or out of place, at the first row boundary. A lost fail flag or a wrapping error count shows up only in `leds` and `err_count` once the final row has been read, so the stimulus includes a single corrupted word, corruption that spans a row boundary, and enough corruption to saturate the counter.

// File: rtl/ddr_pattern_tester.sv
module ddr_pattern_tester #(
  parameter int ROWS   = 9,
  parameter int COLS   = 1024,
  parameter int HALF_W = 16,
  parameter int ERR_W  = 16,
  parameter int LED_W  = 8,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = $clog2(COLS),
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_btn,
  input  logic              wr_take,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_word,
  output logic              cmd_req,
  output logic              cmd_rd,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic [WORD_W-1:0] wr_word,
  output logic              row_done,
  output logic [ERR_W-1:0]  err_count,
  output logic [LED_W-1:0]  leds
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 2);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [ERR_W-1:0] ERR_MAX  = {ERR_W{1'b1}};
  localparam logic [LED_W-1:0] PASS_PAT = LED_W'(1);
  localparam logic [LED_W-1:0] FAIL_PAT = LED_W'(63);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WR_END, S_RD, S_RD_END, S_DONE} state_t;

  state_t            state;
  logic              btn_q;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [HALF_W-1:0] wcnt, ecnt;
  logic [ERR_W-1:0]  errs;
  logic              fail;

  wire go       = start_btn & ~btn_q;
  wire row_end  = (col == LAST_COL);
  wire last_row = (row == LAST_ROW);
  wire [WORD_W-1:0] exp_word = {ecnt, ecnt + HALF_W'(1)};
  wire miss = (state == S_RD) && rd_valid && (rd_word != exp_word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      btn_q <= 1'b0;
      row   <= '0;
      col   <= '0;
      wcnt  <= '0;
      ecnt  <= '0;
      errs  <= '0;
      fail  <= 1'b0;
    end else begin
      btn_q <= start_btn;
      case (state)
        S_IDLE, S_DONE:
          if (go) begin
            state <= S_WR;
            row   <= '0;
            col   <= '0;
            wcnt  <= '0;
            errs  <= '0;
            fail  <= 1'b0;
          end
        S_WR:
          if (wr_take) begin
            wcnt <= wcnt + HALF_W'(2);
            if (row_end) begin
              col   <= '0;
              state <= S_WR_END;
            end else begin
              col <= col + COL_W'(2);
            end
          end
        S_WR_END:
          if (last_row) begin
            row   <= '0;
            ecnt  <= '0;
            state <= S_RD;
          end else begin
            row   <= row + ROW_W'(1);
            state <= S_WR;
          end
        S_RD:
          if (rd_valid) begin
            ecnt <= ecnt + HALF_W'(2);
            if (miss) begin
              fail <= 1'b1;
              if (errs != ERR_MAX) errs <= errs + ERR_W'(1);
            end
            if (row_end) begin
              col   <= '0;
              state <= S_RD_END;
            end else begin
              col <= col + COL_W'(2);
            end
          end
        S_RD_END:
          if (last_row) begin
            state <= S_DONE;
          end else begin
            row   <= row + ROW_W'(1);
            state <= S_RD;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_req   = (state == S_WR) || (state == S_RD);
  assign cmd_rd    = (state == S_RD) || (state == S_RD_END);
  assign row_addr  = row;
  assign col_addr  = col;
  assign wr_word   = {wcnt, wcnt + HALF_W'(1)};
  assign row_done  = (state == S_WR_END) || (state == S_RD_END);
  assign err_count = errs;
  assign leds      = (state != S_DONE) ? '0 : (fail ? FAIL_PAT : PASS_PAT);
endmodule

module ddr_pattern_tester_chk #(
  parameter int ROWS   = 9,
  parameter int COLS   = 1024,
  parameter int HALF_W = 16,
  parameter int ERR_W  = 16,
  parameter int LED_W  = 8,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = $clog2(COLS),
  localparam int WORD_W = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_take,
  input logic              rd_valid,
  input logic              cmd_req,
  input logic              cmd_rd,
  input logic [COL_W-1:0]  col_addr,
  input logic [WORD_W-1:0] wr_word,
  input logic              row_done,
  input logic [ERR_W-1:0]  err_count,
  input logic [LED_W-1:0]  leds
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |=> !row_done);
  a_r4_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> !cmd_req);
  a_r5_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_rd && !wr_take) |=> ($stable(col_addr) && $stable(wr_word)));
  a_r5_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_rd && !rd_valid) |=> $stable(col_addr));
  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_rd && wr_take) |=> (row_done || col_addr == $past(col_addr) + COL_W'(2)));
  a_r7_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> (err_count == $past(err_count) || err_count == $past(err_count) + ERR_W'(1)));
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && err_count == ERR_MAX) |=> err_count == ERR_MAX);
  a_r8_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (leds == LED_W'(1)) |-> (err_count == '0));
  a_r8_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |-> (leds == '0));
endmodule

bind ddr_pattern_tester ddr_pattern_tester_chk #(
  .ROWS(ROWS), .COLS(COLS), .HALF_W(HALF_W), .ERR_W(ERR_W), .LED_W(LED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .rd_valid(rd_valid),
  .cmd_req(cmd_req), .cmd_rd(cmd_rd), .col_addr(col_addr), .wr_word(wr_word),
  .row_done(row_done), .err_count(err_count), .leds(leds)
);

// File: tb/tb_ddr_pattern_tester.sv
module tb_ddr_pattern_tester;
  localparam int ROWS = 9;
  localparam int COLS = 1024;
  localparam int WPR  = COLS / 2;
  localparam int ERR_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0, start_btn = 1'b0, wr_take = 1'b0, rd_valid = 1'b0;
  logic [31:0] rd_word = '0;
  logic        cmd_req, cmd_rd, row_done;
  logic [3:0]  row_addr;
  logic [9:0]  col_addr;
  logic [31:0] wr_word;
  logic [ERR_W-1:0] err_count;
  logic [7:0]  leds;

  ddr_pattern_tester #(.ROWS(ROWS), .COLS(COLS), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_btn(start_btn), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_word(rd_word), .cmd_req(cmd_req), .cmd_rd(cmd_rd),
    .row_addr(row_addr), .col_addr(col_addr), .wr_word(wr_word),
    .row_done(row_done), .err_count(err_count), .leds(leds));

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return {16'(2 * k), 16'(2 * k + 1)};
  endfunction

  // gap, corrupt_lo, corrupt_hi, expected errors
  localparam logic [63:0] RUNS [5] = '{
    {16'd0,  16'd0,    16'd0,    16'd0},
    {16'd7,  16'd0,    16'd0,    16'd0},
    {16'd0,  16'd5,    16'd6,    16'd1},
    {16'd13, 16'd510,  16'd513,  16'd3},
    {16'd0,  16'd4000, 16'd4040, 16'd15}
  };

  task automatic run_test(input int gap, input int lo, input int hi, input int exp_err,
                          input bit disturb);
    start_btn = 1'b1; @(negedge clk); start_btn = 1'b0;
    chk("R10 error count cleared on restart", 32'(err_count), 0);
    chk("R10 leds cleared on restart", 32'(leds), 0);
    for (int r = 0; r < ROWS; r++) begin
      for (int w = 0; w < WPR; w++) begin
        int k = r * WPR + w;
        if (gap != 0 && (w % gap) == gap - 1) begin
          wr_take = 1'b0;
          if (disturb) begin rd_valid = 1'b1; rd_word = 32'hFFFF_FFFF; start_btn = 1'b1; end
          @(negedge clk);
          rd_valid = 1'b0; start_btn = 1'b0;
        end
        chk("R3 write stream", {29'(cmd_req), cmd_rd, row_done, 1'b0}, {29'd1, 1'b0, 1'b0, 1'b0});
        chk(disturb ? "R9 R1 R5 write address" : "R3 R5 write address",
            {22'(row_addr), col_addr}, {22'(r), 10'(2 * w)});
        chk("R2 R5 write word", wr_word, pat(k));
        wr_take = 1'b1;
        @(negedge clk);
      end
      wr_take = 1'b0;
      chk("R4 write row end marker", {31'(row_done), cmd_req}, {31'd1, 1'b0});
      @(negedge clk);
    end
    for (int r = 0; r < ROWS; r++) begin
      for (int w = 0; w < WPR; w++) begin
        int k = r * WPR + w;
        if (gap != 0 && (w % gap) == gap - 1) begin
          rd_valid = 1'b0; rd_word = 32'h0BAD_0BAD;
          if (disturb) begin wr_take = 1'b1; start_btn = 1'b1; end
          @(negedge clk);
          wr_take = 1'b0; start_btn = 1'b0;
        end
        chk("R3 read stream", {29'(cmd_req), cmd_rd, row_done, 1'b0}, {29'd1, 1'b1, 1'b0, 1'b0});
        chk(disturb ? "R9 R1 R5 read address" : "R3 R5 read address",
            {22'(row_addr), col_addr}, {22'(r), 10'(2 * w)});
        rd_word  = (k >= lo && k < hi) ? ~pat(k) : pat(k);
        rd_valid = 1'b1;
        @(negedge clk);
      end
      rd_valid = 1'b0;
      chk("R4 read row end marker", {31'(row_done), cmd_req}, {31'd1, 1'b0});
      @(negedge clk);
    end
    chk(disturb ? "R9 R6 R7 final error count" : "R6 R7 final error count",
        32'(err_count), 32'(exp_err));
    chk("R8 result leds", 32'(leds), (exp_err != 0) ? 32'h3F : 32'h01);
    chk("R8 no request when done", 32'(cmd_req), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset request", 32'(cmd_req), 0);
    chk("R1 reset marker", 32'(row_done), 0);
    chk("R1 reset errors", 32'(err_count), 0);
    chk("R1 reset leds", 32'(leds), 0);
    wr_take = 1'b1; rd_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle until start", {31'(cmd_req), row_done}, 0);
    chk("R1 idle address", {22'(row_addr), col_addr}, 0);
    wr_take = 1'b0; rd_valid = 1'b0;

    for (int i = 0; i < 5; i++) begin
      logic [63:0] e = RUNS[i];
      run_test(int'(e[63:48]), int'(e[47:32]), int'(e[31:16]), int'(e[15:0]), 1'b0);
    end
    run_test(5, 0, 0, 0, 1'b1);
    run_test(0, 0, 1, 1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule